// File: doc/BRIEF.md
# CRC4 Error-Rate Resynchronization Monitor

This block sits behind a CRC4 checker in a 2048 kbit/s receive framer. While multiframe alignment holds, it receives one strobe per checked submultiframe together with a flag that says whether that submultiframe's CRC failed. It counts submultiframes in fixed blocks of `WINDOW`, and errored submultiframes within the current block. When the error count in a block reaches `THRESH`, the block concludes that the frame alignment is false.

On that conclusion it raises a one-cycle request. The alignment logic answers the request with a fresh search for both basic-frame and multiframe alignment, starting just after the previous basic frame alignment signal. The monitor is armed only while the automatic resynchronization enable is set. It stops counting while multiframe alignment is lost. When alignment is regained it starts again from empty counters.

Top module: `crc4_resync_monitor`

## Requirements
- R1: While `auto_resync_en_i` is low, `resync_req_o` stays low and both counters are held at zero, so counting starts from an empty block when the enable returns.
- R2: A strobe with `crc_err_i` high that is the `THRESH`-th (default 915) counted error of the current block makes `resync_req_o` high in the cycle after the clock edge that samples it. The block end is not awaited.
- R3: A block holds `WINDOW` (default 1000) counted strobes. After the last one, the submultiframe count and the error count both restart at zero. Errors never carry from one block into the next.
- R4: While `mf_sync_i` is low, strobes and error flags have no effect. `crc_err_i` is ignored in every cycle where `smf_valid_i` is low.
- R5: A cycle with `mf_sync_i` high after a cycle with it low counts as regained sync. It clears both counters, and a strobe in that same cycle counts as the first of the new block.
- R6: `resync_req_o` is high for one cycle only. Further errors in the same block after the threshold raise no second request.
- R7: When the `THRESH`-th error lands on the last strobe of a block, the request is still issued and the next block starts empty.
- R8: After `rst_ni` is asserted, `resync_req_o` is low and both counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smf_valid_i | input | 1 | One-cycle strobe per checked submultiframe |
| crc_err_i | input | 1 | CRC check of the strobed submultiframe failed |
| mf_sync_i | input | 1 | Multiframe alignment currently held |
| auto_resync_en_i | input | 1 | Enables the error-rate monitor |
| resync_req_o | output | 1 | One-cycle request for a new basic and multiframe alignment search |

## Verification
The threshold detection and the end of a block can fall on the same strobe. The bench provokes this with 85 clean submultiframes followed by 915 errored ones, so the 915th error is also the 1000th strobe. The check passes only if the request appears one cycle later and the block that follows again needs a full 915 errors before it fires. A reference count in the scoreboard predicts the request for every cycle, including the idle cycles between strobes. It also predicts the cycle of sync regain in which a strobe arrives.

// File: rtl/crc4_mon_pkg.sv
package crc4_mon_pkg;
  localparam int unsigned SMF_WINDOW = 1000;
  localparam int unsigned ERR_LIMIT  = 915;
endpackage

// File: rtl/crc4_smf_window.sv
module crc4_smf_window #(
  parameter int unsigned WINDOW = crc4_mon_pkg::SMF_WINDOW
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic restart_i,
  input  logic step_i,
  output logic wrap_o
);
  localparam int unsigned CW = $clog2(WINDOW);
  localparam logic [CW-1:0] LAST = CW'(WINDOW - 1);

  logic [CW-1:0] cnt_q;

  assign wrap_o = step_i && !restart_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (clr_i)       cnt_q <= '0;
    else if (restart_i)   cnt_q <= step_i ? CW'(1) : '0;
    else if (step_i)      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
  end
endmodule

// File: rtl/crc4_err_thresh.sv
module crc4_err_thresh #(
  parameter int unsigned WINDOW = crc4_mon_pkg::SMF_WINDOW,
  parameter int unsigned THRESH = crc4_mon_pkg::ERR_LIMIT
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic restart_i,
  input  logic step_i,
  input  logic err_i,
  input  logic wrap_i,
  output logic hit_o
);
  localparam int unsigned CW = $clog2(WINDOW + 1);
  localparam logic [CW-1:0] PRE_HIT = CW'(THRESH - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] base;

  // regain starts counting from an empty block in the same cycle
  assign base  = restart_i ? '0 : cnt_q;
  assign hit_o = step_i && err_i && (base == PRE_HIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (clr_i)       cnt_q <= '0;
    else if (restart_i)   cnt_q <= CW'(step_i && err_i);
    else if (step_i)      cnt_q <= wrap_i ? '0 : cnt_q + CW'(err_i);
  end
endmodule

// File: rtl/crc4_resync_monitor.sv
module crc4_resync_monitor #(
  parameter int unsigned WINDOW = crc4_mon_pkg::SMF_WINDOW,
  parameter int unsigned THRESH = crc4_mon_pkg::ERR_LIMIT
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic smf_valid_i,
  input  logic crc_err_i,
  input  logic mf_sync_i,
  input  logic auto_resync_en_i,
  output logic resync_req_o
);
  logic sync_q;
  logic regain;
  logic step;
  logic clr;
  logic wrap;
  logic hit;

  assign regain = mf_sync_i && !sync_q && auto_resync_en_i;
  assign step   = smf_valid_i && mf_sync_i && auto_resync_en_i;
  assign clr    = !auto_resync_en_i;

  crc4_smf_window #(.WINDOW(WINDOW)) i_win (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr),
    .restart_i (regain),
    .step_i    (step),
    .wrap_o    (wrap)
  );

  crc4_err_thresh #(.WINDOW(WINDOW), .THRESH(THRESH)) i_err (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr),
    .restart_i (regain),
    .step_i    (step),
    .err_i     (crc_err_i),
    .wrap_i    (wrap),
    .hit_o     (hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q       <= 1'b0;
      resync_req_o <= 1'b0;
    end else begin
      sync_q       <= mf_sync_i;
      resync_req_o <= hit;
    end
  end
endmodule

// File: rtl/crc4_resync_monitor_chk.sv
module crc4_resync_monitor_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic smf_valid_i,
  input logic crc_err_i,
  input logic mf_sync_i,
  input logic auto_resync_en_i,
  input logic resync_req_o
);
  p_off_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !auto_resync_en_i |=> !resync_req_o);

  p_req_from_err_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resync_req_o |-> $past(smf_valid_i && crc_err_i));

  p_nosync_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mf_sync_i |=> !resync_req_o);

  p_single_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resync_req_o |=> !resync_req_o);

  always @(posedge clk_i)
    if (!rst_ni) p_reset_low_r8: assert (!resync_req_o);
endmodule

bind crc4_resync_monitor crc4_resync_monitor_chk i_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .smf_valid_i      (smf_valid_i),
  .crc_err_i        (crc_err_i),
  .mf_sync_i        (mf_sync_i),
  .auto_resync_en_i (auto_resync_en_i),
  .resync_req_o     (resync_req_o)
);

// File: tb/test_crc4_resync_monitor.sv
module test_crc4_resync_monitor;
  localparam int W = 1000;
  localparam int T = 915;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic smf_valid_i = 1'b0;
  logic crc_err_i = 1'b0;
  logic mf_sync_i = 1'b0;
  logic auto_resync_en_i = 1'b0;
  logic resync_req_o;

  always #2 clk = ~clk;

  crc4_resync_monitor i_crc4_resync_monitor (
    .clk_i            (clk),
    .rst_ni           (rst_ni),
    .smf_valid_i      (smf_valid_i),
    .crc_err_i        (crc_err_i),
    .mf_sync_i        (mf_sync_i),
    .auto_resync_en_i (auto_resync_en_i),
    .resync_req_o     (resync_req_o)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  bit exp_q[$];
  string tag_q[$];
  string tag = "R8";

  int m_smf = 0;
  int m_err = 0;
  bit m_sync_q = 1'b0;
  bit sync_v = 1'b0;
  bit en_v = 1'b0;

  // scoreboard monitor
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      bit e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (resync_req_o !== e) begin
        failures++;
        $display("FAIL %s: resync_req_o=%b expected=%b at %0t", t, resync_req_o, e, $time);
      end
    end
  end

  // driver: one cycle of stimulus, expected result from the reference count
  task automatic cyc(input bit v, input bit e);
    bit exp;
    bit regain;
    @(negedge clk);
    smf_valid_i = v;
    crc_err_i = e;
    mf_sync_i = sync_v;
    auto_resync_en_i = en_v;
    exp = 1'b0;
    regain = sync_v && !m_sync_q;
    if (!en_v) begin
      m_smf = 0; m_err = 0;
    end else if (regain) begin
      m_smf = v ? 1 : 0;
      m_err = (v && e) ? 1 : 0;
      exp = (v && e && T == 1);
    end else if (sync_v && v) begin
      if (e && (m_err + 1 == T)) exp = 1'b1;
      if (m_smf == W - 1) begin
        m_smf = 0; m_err = 0;
      end else begin
        m_smf++; m_err += e ? 1 : 0;
      end
    end
    m_sync_q = sync_v;
    @(posedge clk);
    #1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  // a strobe, then an idle cycle with a stray error flag (R4)
  task automatic smf(input bit e);
    cyc(1'b1, e);
    cyc(1'b0, 1'b1);
  endtask

  task automatic smfs(input int n, input bit e);
    for (int i = 0; i < n; i++) smf(e);
  endtask

  task automatic finish_run;
    if (done) return;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (resync_req_o !== 1'b0) begin
      failures++;
      $display("FAIL R8: resync_req_o=%b expected=0 in reset", resync_req_o);
    end
    @(negedge clk);
    rst_ni = 1'b1;
    tag = "R8";
    cyc(1'b0, 1'b0); cyc(1'b0, 1'b0);

    // R2 / R6: threshold mid-block, further errors give no second pulse
    sync_v = 1'b1; en_v = 1'b1;
    tag = "R5_first_sync";
    cyc(1'b0, 1'b0);
    tag = "R2";
    smfs(T, 1'b1);
    tag = "R6";
    smfs(W - T, 1'b1);

    // R3: errors just below threshold in consecutive blocks never fire
    tag = "R3";
    smfs(T - 1, 1'b1); smfs(W - T + 1, 1'b0);
    smfs(W - T + 1, 1'b0); smfs(T - 1, 1'b1);

    // R7: threshold on the last strobe of a block, then a full fresh block
    tag = "R7";
    smfs(W - T, 1'b0); smfs(T, 1'b1);
    tag = "R3_after_wrap";
    smfs(T, 1'b1); smfs(W - T, 1'b0);

    // R4: errors while sync is lost are ignored
    tag = "R4";
    smfs(900, 1'b1);
    sync_v = 1'b0;
    smfs(W, 1'b1);
    // R5: regain clears, strobe in the regain cycle counts as first
    sync_v = 1'b1;
    tag = "R5";
    smf(1'b1);
    smfs(T - 2, 1'b1);
    smf(1'b1);

    // R1: disabled monitor ignores errors and holds counters at zero
    tag = "R1";
    smfs(10, 1'b0);
    en_v = 1'b0;
    smfs(W, 1'b1);
    en_v = 1'b1;
    smfs(T - 1, 1'b1);
    tag = "R1_reenabled";
    smf(1'b1);
    smfs(20, 1'b0);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule